// File: doc/BRIEF.md
# Caller Feed Routing Controller

This block holds the control state for one telephone-caller channel strip on a broadcast mixing console. Two single-cycle button pulses switch the strip on and off. A registered, one-hot select then chooses which bus is returned to the caller: one of the program mix-minus buses or the off-line bus. The block also tells the downstream summing logic whether the second caller's audio is added to the left tape output or to the right one. When the matching options are set, it raises a one-cycle cue-clear pulse and a one-cycle timer-reset pulse.

The block carries no data stream. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure. Audio summing and analog switching sit outside the block and act on the selects it drives.

Encodings: `feed_sel_i` is 0 for program bus 1, 1 for program bus 2, 2 for program bus 3 and 3 for the off-line bus. In `caller_feed_o`, bit 0 is program bus 1, bit 1 is program bus 2, bit 2 is program bus 3 and bit 3 is the off-line bus.

Top module: `caller_route_ctrl`

## Requirements
- R1: After reset the strip is off, `caller_feed_o` is 4'b1000 (off-line), and `cue_clear_o`, `timer_reset_o`, `tape_left_other_o` and `tape_right_other_o` are all low.
- R2: At the clock edge that samples it, a pulse on `on_btn_i` alone sets `module_on_o` and a pulse on `off_btn_i` alone clears it. When both are high in the same cycle, the state is unchanged.
- R3: With `auto_feed_i` high and the strip on, the feed one cycle later is the bus that `feed_sel_i` selects.
- R4: With `auto_feed_i` high and the strip off, the feed one cycle later is the off-line bus (bit 3), whatever the selection.
- R5: With `auto_feed_i` low, the feed one cycle later is the bus `feed_sel_i` selects, whether the strip is on or off.
- R6: When `feed_sel_i` is 3 (off-line), the feed one cycle later has no program bit set (bits 0 to 2 low), even while the strip is on with auto-feed active.
- R7: `caller_feed_o` is a registered select with exactly one bit set in every cycle after reset.
- R8: With `cue_reset_en_i` high, `cue_clear_o` is high for exactly the one cycle in which `module_on_o` takes a new value, in either direction. With the option low, it stays low.
- R9: With `timer_reset_en_i` high, `timer_reset_o` is high for exactly the one cycle in which `module_on_o` rises. It never pulses on an on-to-off change or when the option is low.
- R10: With `second_present_i` low, one cycle later both `tape_left_other_o` and `tape_right_other_o` are low, whatever `tape_to_right_i` is.
- R11: With `second_present_i` high, one cycle later `tape_left_other_o` is high when `tape_to_right_i` is low, and `tape_right_other_o` is high when it is high. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_btn_i | input | 1 | One-cycle request to switch the strip on |
| off_btn_i | input | 1 | One-cycle request to switch the strip off |
| feed_sel_i | input | 2 | Manually chosen caller source (0..2 program bus, 3 off-line) |
| auto_feed_i | input | 1 | Feed follows on/off state when high |
| cue_reset_en_i | input | 1 | Clear cue on any on/off change |
| timer_reset_en_i | input | 1 | Request timer reset on switch-on |
| tape_to_right_i | input | 1 | Second caller goes to right tape output when high, left when low |
| second_present_i | input | 1 | A second caller strip is fitted |
| module_on_o | output | 1 | Registered on/off state |
| caller_feed_o | output | 4 | One-hot caller return select |
| cue_clear_o | output | 1 | One-cycle cue clear request |
| timer_reset_o | output | 1 | One-cycle timer reset request |
| tape_left_other_o | output | 1 | Add second caller to left tape output |
| tape_right_other_o | output | 1 | Add second caller to right tape output |

## Verification
Some properties are checked on every cycle: the feed stays one-hot, the feed follows auto-feed and the manual choice with one cycle of latency, the off-line choice never reaches a program bus, both buttons together leave the state alone, the pulses only coincide with the state changes they belong to, and the tape routing is exclusive and needs a second strip. The scenarios are needed for the behaviour over longer sequences. They show that each pulse lasts exactly one cycle, that switching off never resets the timer, that changing the selection while on swaps the bus at once, and that the reset state is right before the first edge.

// File: rtl/caller_route_pkg.sv
package caller_route_pkg;
  localparam int NUM_PGM     = 3;
  localparam int FEED_W      = NUM_PGM + 1;
  localparam int OFFLINE_IDX = NUM_PGM;
  localparam int SEL_W       = $clog2(FEED_W);

  localparam logic [FEED_W-1:0] FEED_OFFLINE = FEED_W'(1) << OFFLINE_IDX;
  localparam logic [SEL_W-1:0]  SEL_OFFLINE  = SEL_W'(OFFLINE_IDX);
endpackage

// File: rtl/caller_onoff.sv
module caller_onoff (
  input  logic clk,
  input  logic rst_n,
  input  logic on_btn_i,
  input  logic off_btn_i,
  input  logic cue_en_i,
  input  logic tmr_en_i,
  output logic on_o,
  output logic cue_clr_o,
  output logic tmr_rst_o
);
  logic on_q, on_d;
  logic cue_q, tmr_q;

  always_comb begin
    on_d = on_q;
    if (on_btn_i && !off_btn_i)      on_d = 1'b1;
    else if (off_btn_i && !on_btn_i) on_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cue_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      cue_q <= cue_en_i && (on_d != on_q);
      tmr_q <= tmr_en_i && on_d && !on_q;
    end
  end

  assign on_o      = on_q;
  assign cue_clr_o = cue_q;
  assign tmr_rst_o = tmr_q;

  AST_BOTH_BTN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (on_btn_i && off_btn_i) |=> $stable(on_q)); // R2
  AST_CUE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cue_en_i && !on_q && on_btn_i && !off_btn_i) |=> (cue_q && on_q)); // R8
  AST_CUE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_btn_i == off_btn_i) |=> !cue_q); // R8
  AST_TMR_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_q || !on_btn_i || off_btn_i) && !(on_btn_i && !off_btn_i && !on_q) |=> !tmr_q); // R9
endmodule

// File: rtl/caller_feed_sel.sv
module caller_feed_sel
  import caller_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_i,
  input  logic              auto_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [FEED_W-1:0] feed_o
);
  logic [SEL_W-1:0]  eff_idx;
  logic [FEED_W-1:0] feed_d, feed_q;

  always_comb begin
    if (auto_i && !on_i) eff_idx = SEL_OFFLINE;
    else                 eff_idx = sel_i;
  end

  for (genvar g = 0; g < FEED_W; g++) begin : g_dec
    assign feed_d[g] = (eff_idx == SEL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) feed_q <= FEED_OFFLINE;
    else        feed_q <= feed_d;
  end

  assign feed_o = feed_q;

  AST_FEED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(feed_q) == 1); // R7
  AST_AUTO_ON_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && on_i) |=> feed_q[$past(sel_i)]); // R3
  AST_AUTO_OFF_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && !on_i) |=> feed_q[OFFLINE_IDX]); // R4
  AST_MANUAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_i |=> feed_q[$past(sel_i)]); // R5
  AST_OFFLINE_NO_AIR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_OFFLINE) |=> (feed_q[NUM_PGM-1:0] == '0)); // R6
endmodule

// File: rtl/caller_tape_route.sv
module caller_tape_route (
  input  logic clk,
  input  logic rst_n,
  input  logic second_i,
  input  logic to_right_i,
  output logic left_other_o,
  output logic right_other_o
);
  logic left_q, right_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= 1'b0;
      right_q <= 1'b0;
    end else begin
      left_q  <= second_i && !to_right_i;
      right_q <= second_i && to_right_i;
    end
  end

  assign left_other_o  = left_q;
  assign right_other_o = right_q;

  AST_SINGLE_NO_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    !second_i |=> (!left_q && !right_q)); // R10
  AST_TAPE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_q && right_q)); // R11
  AST_TAPE_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    second_i |=> (left_q || right_q)); // R11
endmodule

// File: rtl/caller_route_ctrl.sv
module caller_route_ctrl
  import caller_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_btn_i,
  input  logic              off_btn_i,
  input  logic [SEL_W-1:0]  feed_sel_i,
  input  logic              auto_feed_i,
  input  logic              cue_reset_en_i,
  input  logic              timer_reset_en_i,
  input  logic              tape_to_right_i,
  input  logic              second_present_i,
  output logic              module_on_o,
  output logic [FEED_W-1:0] caller_feed_o,
  output logic              cue_clear_o,
  output logic              timer_reset_o,
  output logic              tape_left_other_o,
  output logic              tape_right_other_o
);
  logic on_w;

  caller_onoff u_onoff (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_btn_i  (on_btn_i),
    .off_btn_i (off_btn_i),
    .cue_en_i  (cue_reset_en_i),
    .tmr_en_i  (timer_reset_en_i),
    .on_o      (on_w),
    .cue_clr_o (cue_clear_o),
    .tmr_rst_o (timer_reset_o)
  );

  caller_feed_sel u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .on_i   (on_w),
    .auto_i (auto_feed_i),
    .sel_i  (feed_sel_i),
    .feed_o (caller_feed_o)
  );

  caller_tape_route u_tape (
    .clk           (clk),
    .rst_n         (rst_n),
    .second_i      (second_present_i),
    .to_right_i    (tape_to_right_i),
    .left_other_o  (tape_left_other_o),
    .right_other_o (tape_right_other_o)
  );

  assign module_on_o = on_w;

  AST_TIMER_WITH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    timer_reset_o |-> module_on_o); // R9
endmodule

// File: tb/caller_route_ctrl_bench.sv
`timescale 1ns/1ps
module caller_route_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_btn = 0, off_btn = 0, auto_f = 0, cue_en = 0, tmr_en = 0, to_right = 0, second = 0;
  logic [1:0] sel = 2'd0;
  logic on_o, cue_o, tmr_o, lo_o, ro_o;
  logic [3:0] feed_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       on;
    logic [3:0] feed;
    logic       cue, tmr, lo, ro;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic m_on = 1'b0;

  always #10 clk = ~clk;

  caller_route_ctrl u_caller_route_ctrl (
    .clk(clk), .rst_n(rst_n), .on_btn_i(on_btn), .off_btn_i(off_btn),
    .feed_sel_i(sel), .auto_feed_i(auto_f), .cue_reset_en_i(cue_en),
    .timer_reset_en_i(tmr_en), .tape_to_right_i(to_right),
    .second_present_i(second), .module_on_o(on_o), .caller_feed_o(feed_o),
    .cue_clear_o(cue_o), .timer_reset_o(tmr_o),
    .tape_left_other_o(lo_o), .tape_right_other_o(ro_o)
  );

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: called at a negedge; sets inputs and queues the values expected after the next edge.
  task automatic tick(input logic onb, input logic offb, input string tag);
    exp_t e;
    logic nxt;
    on_btn  = onb;
    off_btn = offb;
    nxt = m_on;
    if (onb && !offb) nxt = 1'b1;
    else if (offb && !onb) nxt = 1'b0;
    e.on   = nxt;
    e.feed = (auto_f && !m_on) ? 4'b1000 : (4'b0001 << sel);
    e.cue  = cue_en && (nxt != m_on);
    e.tmr  = tmr_en && nxt && !m_on;
    e.lo   = second && !to_right;
    e.ro   = second && to_right;
    e.tag  = tag;
    q.push_back(e);
    m_on = nxt;
    @(negedge clk);
    on_btn  = 1'b0;
    off_btn = 1'b0;
  endtask

  // Monitor: samples 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "on",   {3'b0, on_o},  {3'b0, e.on});
        chk(e.tag, "feed", feed_o,        e.feed);
        chk(e.tag, "cue",  {3'b0, cue_o}, {3'b0, e.cue});
        chk(e.tag, "tmr",  {3'b0, tmr_o}, {3'b0, e.tmr});
        chk(e.tag, "lo",   {3'b0, lo_o},  {3'b0, e.lo});
        chk(e.tag, "ro",   {3'b0, ro_o},  {3'b0, e.ro});
        chk("R7", "onehot", 4'($countones(feed_o)), 4'd1);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, checked before any active edge
    chk("R1", "on",   {3'b0, on_o}, 4'd0);
    chk("R1", "feed", feed_o, 4'b1000);
    chk("R1", "pulses", {2'b0, cue_o, tmr_o}, 4'd0);
    chk("R1", "tape", {2'b0, lo_o, ro_o}, 4'd0);

    // R10 single strip: no second caller on either tape side
    to_right = 1'b1; tick(0, 0, "R10");
    to_right = 1'b0; tick(0, 0, "R10");

    // R5 manual selection while off
    for (int s = 0; s < 4; s++) begin sel = 2'(s); tick(0, 0, "R5"); end

    // R2 / R8 / R9 on-off with options set
    sel = 2'd1; cue_en = 1; tmr_en = 1;
    tick(1, 0, "R9");
    tick(0, 0, "R8");
    tick(1, 1, "R2");
    tick(1, 0, "R2");
    tick(0, 1, "R8");
    tick(0, 0, "R9");
    // R5 manual while on
    tick(1, 0, "R5");
    sel = 2'd2; tick(0, 0, "R5");
    // R8 / R9 disabled options
    cue_en = 0; tmr_en = 0;
    tick(0, 1, "R8");
    tick(1, 0, "R9");

    // R3 auto-feed while on
    auto_f = 1; sel = 2'd0; tick(0, 0, "R3");
    sel = 2'd1; tick(0, 0, "R3");
    // R4 auto-feed while off
    tick(0, 1, "R4");
    sel = 2'd2; tick(0, 0, "R4");
    tick(0, 0, "R4");

    // R6 off-line selected never reaches program bus
    sel = 2'd3; tick(1, 0, "R6");
    tick(0, 0, "R6");
    auto_f = 0; tick(0, 0, "R6");

    // R11 second strip fitted
    second = 1; to_right = 0; tick(0, 0, "R11");
    to_right = 1; tick(0, 0, "R11");
    tick(0, 0, "R11");
    second = 0; tick(0, 0, "R10");
    tick(0, 0, "R10");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule